// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This unit carries out the eight accumulator operations of a small 8-bit processor: add, add with carry, subtract, subtract with borrow, bitwise and, exclusive or, inclusive or, and compare. The sequencer pulses `start` with an opcode of the form `10 ooo sss`. The unit also receives the current accumulator, the current flag byte and the six general registers. One cycle later it presents the new accumulator and flag byte together with a one-cycle `done` pulse.

When the source field names the memory operand, the unit spends one extra cycle on the bus. In that cycle it asserts a read request at the address formed from H (high byte) and L (low byte). It computes the result from the returned byte on the following edge. Results stay on `acc_out` and `flags_out` until the next completed operation.

Top module: `accum_alu`

## Requirements
- R1: An opcode is accepted on `start` only when bits 7:6 are `10`. Any other opcode is ignored: `done` stays low and `acc_out`/`flags_out` keep their values.
- R2: Bits 2:0 select the operand: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 the accumulator itself, and 110 the memory byte at address {H,L}.
- R3: The flag byte holds C in bit 4, H in bit 5, N in bit 6 and Z in bit 7. Bits 3:0 of `flags_out` copy bits 3:0 of the flag byte that was presented with the instruction.
- R4: Bits 5:3 select the operation. For add (000) and add with carry (001), the 8-bit sum is written to the accumulator. Add with carry also adds incoming flag bit 4. Z is set when the sum is zero, N is cleared, H is set on a carry out of bit 3 and C is set on a carry out of bit 7.
- R5: Subtract (010) and subtract with borrow (011) write the difference to the accumulator. Subtract with borrow also subtracts incoming flag bit 4. N is set, Z is set when the result is zero, H is set on a borrow from bit 4 and C is set on a borrow out of bit 7.
- R6: Compare (111) sets the flags exactly as subtract does and leaves the accumulator equal to the accumulator input.
- R7: And (100) sets H and clears N and C. Exclusive or (101) and or (110) clear N, H and C. All three set Z from their 8-bit result, which is written to the accumulator.
- R8: For a memory operand, `mem_rd` is high for exactly the one cycle after `start`, with `mem_addr` = {H,L}. `done` rises one cycle later, and the result uses the `mem_rdata` present during the read cycle.
- R9: For a register operand, `done` pulses in the cycle after `start`. A `start` that arrives while a memory read is pending is ignored.
- R10: After reset, `acc_out`, `flags_out`, `mem_addr` are zero and `done` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the opcode this cycle |
| opcode | input | 8 | Instruction byte `10 ooo sss` |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H, high address byte |
| reg_l | input | 8 | Register L, low address byte |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid while `mem_rd` is high |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | Result valid pulse |

## Verification
The properties assume that memory returns its byte in the same cycle as the request. They also assume that `acc_in` and the operand registers are only meaningful on the `start` cycle. The bench drives all inputs half a cycle before the sampling edge. It presents `mem_rdata` throughout the read cycle and pulses `start` for one cycle only. The exception is the one deliberate overlap used to show that a busy unit drops a new request.

// File: rtl/accum_alu.sv
module accum_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  flags_in,
  input  logic [7:0]  reg_b,
  input  logic [7:0]  reg_c,
  input  logic [7:0]  reg_d,
  input  logic [7:0]  reg_e,
  input  logic [7:0]  reg_h,
  input  logic [7:0]  reg_l,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  acc_out,
  output logic [7:0]  flags_out,
  output logic        done
);

  logic       pending;
  logic [2:0] op_q;
  logic [7:0] acc_q;
  logic [7:0] flg_q;
  logic [7:0] src_val;
  logic       accept;
  logic       from_mem;

  assign accept   = start && (opcode[7:6] == 2'b10) && !pending;
  assign from_mem = (opcode[2:0] == 3'b110);
  assign mem_rd   = pending;

  always_comb begin
    case (opcode[2:0])
      3'b000:  src_val = reg_b;
      3'b001:  src_val = reg_c;
      3'b010:  src_val = reg_d;
      3'b011:  src_val = reg_e;
      3'b100:  src_val = reg_h;
      3'b101:  src_val = reg_l;
      3'b111:  src_val = acc_in;
      default: src_val = 8'h00;
    endcase
  end

  function automatic logic [15:0] alu_eval(input logic [2:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [7:0] f);
    logic       cin;
    logic [8:0] wide;
    logic [4:0] nib;
    logic [7:0] res;
    logic       zf, nf, hf, cf;
    cin  = (op == 3'b001 || op == 3'b011) ? f[4] : 1'b0;
    wide = 9'd0;
    nib  = 5'd0;
    res  = a;
    nf   = 1'b0;
    hf   = 1'b0;
    cf   = 1'b0;
    case (op)
      3'b000, 3'b001: begin
        wide = {1'b0, a} + {1'b0, b} + {8'd0, cin};
        nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
        res  = wide[7:0];
        hf   = nib[4];
        cf   = wide[8];
      end
      3'b010, 3'b011, 3'b111: begin
        wide = {1'b0, a} - {1'b0, b} - {8'd0, cin};
        nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, cin};
        res  = wide[7:0];
        nf   = 1'b1;
        hf   = nib[4];
        cf   = wide[8];
      end
      3'b100: begin
        res = a & b;
        hf  = 1'b1;
      end
      3'b101: res = a ^ b;
      default: res = a | b;
    endcase
    zf = (res == 8'h00);
    return {(op == 3'b111) ? a : res, zf, nf, hf, cf, f[3:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      done      <= 1'b0;
      mem_addr  <= 16'h0000;
      acc_out   <= 8'h00;
      flags_out <= 8'h00;
      op_q      <= 3'd0;
      acc_q     <= 8'h00;
      flg_q     <= 8'h00;
    end else begin
      done <= 1'b0;
      if (pending) begin
        {acc_out, flags_out} <= alu_eval(op_q, acc_q, mem_rdata, flg_q);
        done    <= 1'b1;
        pending <= 1'b0;
      end else if (accept) begin
        if (from_mem) begin
          pending  <= 1'b1;
          mem_addr <= {reg_h, reg_l};
          op_q     <= opcode[5:3];
          acc_q    <= acc_in;
          flg_q    <= flags_in;
        end else begin
          {acc_out, flags_out} <= alu_eval(opcode[5:3], acc_in, src_val, flags_in);
          done <= 1'b1;
        end
      end
    end
  end

endmodule

module accum_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  opcode,
  input logic [7:0]  acc_in,
  input logic        mem_rd,
  input logic [7:0]  acc_out,
  input logic [7:0]  flags_out,
  input logic        done
);

  assert_mem_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (done && !mem_rd));

  assert_reg_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && opcode[7:6] == 2'b10 && opcode[2:0] != 3'b110) |=> done);

  assert_bad_opcode_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && opcode[7:6] != 2'b10) |=> !done);

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && opcode[7:3] == 5'b10111 && opcode[2:0] != 3'b110)
      |=> (acc_out == $past(acc_in)));

  assert_sub_sets_n_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && opcode[7:4] == 4'b1001 && opcode[2:0] != 3'b110)
      |=> flags_out[6]);

  assert_out_moves_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(acc_out) || !$stable(flags_out)) |-> done);

endmodule

bind accum_alu accum_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc_in(acc_in),
  .mem_rd(mem_rd), .acc_out(acc_out), .flags_out(flags_out), .done(done)
);

// File: tb/accum_alu_test.sv
module accum_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  acc_in = 8'h00;
  logic [7:0]  flags_in = 8'h00;
  logic [7:0]  reg_b = 8'h00, reg_c = 8'h00, reg_d = 8'h00, reg_e = 8'h00;
  logic [7:0]  reg_h = 8'h00, reg_l = 8'h00;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  acc_out, flags_out;
  logic        done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  accum_alu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc_in(acc_in),
    .flags_in(flags_in), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e),
    .reg_h(reg_h), .reg_l(reg_l), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .acc_out(acc_out), .flags_out(flags_out), .done(done)
  );

  // opcode, acc, flags, operand(C), expected acc, expected flags
  localparam logic [47:0] VEC [15] = '{
    {8'h81, 8'h10, 8'h00, 8'h02, 8'h12, 8'h00},
    {8'h81, 8'h0F, 8'h05, 8'h01, 8'h10, 8'h25},
    {8'h81, 8'hFF, 8'h00, 8'h01, 8'h00, 8'hB0},
    {8'h89, 8'h0E, 8'h10, 8'h01, 8'h10, 8'h20},
    {8'h89, 8'hFE, 8'h1A, 8'h01, 8'h00, 8'hBA},
    {8'h91, 8'h10, 8'h00, 8'h01, 8'h0F, 8'h60},
    {8'h91, 8'h05, 8'h00, 8'h05, 8'h00, 8'hC0},
    {8'h91, 8'h00, 8'h00, 8'h01, 8'hFF, 8'h70},
    {8'h99, 8'h10, 8'h10, 8'h0F, 8'h00, 8'hE0},
    {8'h99, 8'h00, 8'h13, 8'h00, 8'hFF, 8'h73},
    {8'hA1, 8'hF0, 8'h10, 8'h0F, 8'h00, 8'hA0},
    {8'hA9, 8'h5A, 8'hF0, 8'h5A, 8'h00, 8'h80},
    {8'hB1, 8'h50, 8'hF0, 8'h0A, 8'h5A, 8'h00},
    {8'hB9, 8'h42, 8'h00, 8'h42, 8'h42, 8'hC0},
    {8'hB9, 8'h10, 8'h00, 8'h20, 8'h10, 8'h50}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    opcode = op; acc_in = a; flags_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 acc", {8'h00, acc_out}, 16'h0000);
    chk("R10 flags", {8'h00, flags_out}, 16'h0000);
    chk("R10 addr", mem_addr, 16'h0000);
    chk("R10 done/rd", {14'd0, done, mem_rd}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      reg_c = VEC[i][23:16];
      issue(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
      chk("R9 done", {15'd0, done}, 16'h0001);
      chk($sformatf("R4/R5/R6/R7/R3 vec%0d", i), {acc_out, flags_out}, VEC[i][15:0]);
    end

    reg_b = 8'h01; reg_c = 8'h02; reg_d = 8'h04; reg_e = 8'h08; reg_h = 8'h21; reg_l = 8'h43;
    for (int s = 0; s < 6; s++) begin
      issue(8'h80 | 8'(s), 8'h00, 8'h00);
      chk($sformatf("R2 src%0d", s), {8'h00, acc_out},
          {8'h00, (s == 0) ? 8'h01 : (s == 1) ? 8'h02 : (s == 2) ? 8'h04 :
                  (s == 3) ? 8'h08 : (s == 4) ? 8'h21 : 8'h43});
    end
    issue(8'h87, 8'h88, 8'h0C);
    chk("R2 src A", {acc_out, flags_out}, {8'h10, 8'h3C});

    issue(8'h41, 8'h77, 8'h00);
    chk("R1 ignored done", {15'd0, done}, 16'h0000);
    chk("R1 ignored outputs", {acc_out, flags_out}, {8'h10, 8'h3C});
    issue(8'hC0, 8'h77, 8'h00);
    chk("R1 ignored top 11", {7'd0, done, acc_out}, {8'h00, 8'h10});

    mem_rdata = 8'h05;
    issue(8'h86, 8'h10, 8'h03);
    chk("R8 read req", {15'd0, mem_rd}, 16'h0001);
    chk("R8 addr", mem_addr, 16'h2143);
    chk("R8 no early done", {15'd0, done}, 16'h0000);
    @(negedge clk);
    chk("R8 done", {14'd0, done, mem_rd}, 16'h0002);
    chk("R8 result", {acc_out, flags_out}, {8'h15, 8'h03});

    mem_rdata = 8'h01;
    issue(8'h96, 8'h01, 8'h00);
    opcode = 8'h80; acc_in = 8'h99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy result", {7'd0, done, acc_out}, {8'h01, 8'h00});
    chk("R5 mem sub flags", {8'h00, flags_out}, 16'h00C0);
    @(negedge clk);
    chk("R9 busy start dropped", {15'd0, done}, 16'h0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule